// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one private write-back cache that sits on a shared snooping bus. Each line is always in one of four states: Modified (the only copy, dirty and writable), Exclusive (the only copy, clean), Shared (clean, other caches may hold it) or Invalid. The CPU side presents one request at a time with a tag-match indication. The controller either completes it at once or sequences the bus transactions it needs: a fill read, a read-for-ownership, an invalidate, or a write-back of a dirty victim. The bus side presents transactions issued by other caches. The controller answers them in the same cycle with a shared indication and a flush of dirty data, and it updates the line.

A wired shared line is sampled when a fill read is granted. When no other cache holds the line, a lone reader receives a clean exclusive copy. It can later write that copy without any bus traffic. The data array, the tag array, main memory and arbitration between caches are outside the block. The tag array supplies the hit inputs, and the bus arbiter supplies the grant.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid. Line states are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3 on `cpu_line_state`, which shows the state of line `cpu_idx`.
- R2: A CPU read with `cpu_hit` high to a Shared, Exclusive or Modified line is acknowledged in the cycle it is presented, with no bus request, and the state is unchanged.
- R3: A CPU read to an Invalid line, or with `cpu_hit` low, issues a bus Read (op code 0). When granted, the line becomes Exclusive if `bus_shared_in` is low and Shared if it is high.
- R4: A CPU write to an Invalid line, or with `cpu_hit` low, issues a bus ReadX (op code 1), and the line becomes Modified when granted.
- R5: A CPU write with `cpu_hit` high to an Exclusive or Modified line is acknowledged in the cycle it is presented, with no bus request, and the line becomes Modified.
- R6: A CPU write with `cpu_hit` high to a Shared line issues a bus Invalidate (op code 2). The write completes and the line becomes Modified only when that Invalidate is granted.
- R7: A snooped Read (`snp_op`=0) with `snp_hit` high to an Exclusive or Shared line raises `snp_shared_out` in the same cycle, does not flush, and leaves the line Shared.
- R8: A snooped Read with `snp_hit` high to a Modified line raises both `snp_flush` and `snp_shared_out`, and leaves the line Shared.
- R9: A snooped ReadX (`snp_op`=1) or Invalidate (`snp_op`=2) with `snp_hit` high to a Modified line raises `snp_flush` and leaves the line Invalid.
- R10: A snooped ReadX or Invalidate with `snp_hit` high to a Shared or Exclusive line leaves it Invalid with no flush and no shared response. A snoop with `snp_hit` low, to an Invalid line, or with `snp_op`=3 has no response and no effect.
- R11: A CPU miss (`cpu_hit` low) whose indexed line is Modified first issues a WriteBack (op code 3). Only after that WriteBack is granted does it issue the fill Read or ReadX.
- R12: A snoop to the same index as a CPU request is served first. The CPU request is not acted on in that cycle and any bus request it has pending is withdrawn. It is then retried against the state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request valid, held until `cpu_ack` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IW | Line index of the request, also selects `cpu_line_state` |
| cpu_hit | input | 1 | Tag match for `cpu_idx` |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_line_state | output | 2 | Current state of line `cpu_idx` |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped op: 0 Read, 1 ReadX, 2 Invalidate, 3 none |
| snp_idx | input | IW | Line index of the snooped transaction |
| snp_hit | input | 1 | Tag match for `snp_idx` |
| snp_shared_out | output | 1 | Drive of the wired shared line |
| snp_flush | output | 1 | Dirty data must be flushed on the bus |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 2 | 0 Read, 1 ReadX, 2 Invalidate, 3 WriteBack |
| bus_gnt | input | 1 | Requested transaction is granted and completes this cycle |
| bus_shared_in | input | 1 | Wired shared line, sampled at a fill grant |

## Verification
The bench builds the block with eight lines. That number is small enough for random traffic to land repeatedly on the same line, so a line walks through every state pair, and dirty victims, upgrades and snoop downgrades recur on the lines that the directed cases have set up. Grants are delayed by up to a few cycles, which keeps a transaction pending while other activity goes on. One directed case puts a conflicting snoop onto a pending upgrade.

// File: rtl/mesi_lc_pkg.sv
package mesi_lc_pkg;

   typedef enum logic [1:0] {
      LS_I = 2'd0,
      LS_S = 2'd1,
      LS_E = 2'd2,
      LS_M = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BOP_RD  = 2'd0,
      BOP_RDX = 2'd1,
      BOP_INV = 2'd2,
      BOP_WB  = 2'd3
   } bus_op_e;

   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_WB   = 2'd1,
      CS_UPG  = 2'd2,
      CS_FILL = 2'd3
   } ctl_st_e;

   typedef struct packed {
      logic     upd;
      line_st_e nxt;
      logic     shared;
      logic     flush;
   } snp_resp_t;

endpackage

// File: rtl/mesi_lc_state_array.sv
module mesi_lc_state_array
   import mesi_lc_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    ra_idx,
   output line_st_e         ra_st,
   input  logic [IW-1:0]    rb_idx,
   output line_st_e         rb_st,
   input  logic             wa_en,
   input  logic [IW-1:0]    wa_idx,
   input  line_st_e         wa_st,
   input  logic             wb_en,
   input  logic [IW-1:0]    wb_idx,
   input  line_st_e         wb_st
);

   initial begin
      assert (LINES >= 2 && (LINES & (LINES - 1)) == 0)
         else $error("mesi_lc_state_array: LINES must be a power of two >= 2");
   end

   line_st_e st_vec [LINES];

   // one state register per line; port A (snoop) wins over port B (CPU)
   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         line_st_e q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= LS_I;
            else if (wa_en && wa_idx == IW'(g))
               q <= wa_st;
            else if (wb_en && wb_idx == IW'(g))
               q <= wb_st;
         end
         assign st_vec[g] = q;
      end
   endgenerate

   assign ra_st = st_vec[ra_idx];
   assign rb_st = st_vec[rb_idx];

endmodule

// File: rtl/mesi_lc_snoop.sv
module mesi_lc_snoop
   import mesi_lc_pkg::*;
(
   input  logic       snp_valid,
   input  logic [1:0] snp_op,
   input  logic       snp_hit,
   input  line_st_e   cur,
   output snp_resp_t  resp
);

   always_comb begin
      resp        = '0;
      resp.nxt    = cur;
      if (snp_valid && snp_hit && cur != LS_I) begin
         unique case (snp_op)
            2'd0: begin
               resp.upd    = 1'b1;
               resp.nxt    = LS_S;
               resp.shared = 1'b1;
               resp.flush  = (cur == LS_M);
            end
            2'd1, 2'd2: begin
               resp.upd    = 1'b1;
               resp.nxt    = LS_I;
               resp.flush  = (cur == LS_M);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mesi_lc_cpu_fsm.sv
module mesi_lc_cpu_fsm
   import mesi_lc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_req,
   input  logic       cpu_wr,
   input  logic       cpu_hit,
   input  line_st_e   cur,
   input  logic       conflict,
   input  logic       bus_gnt,
   input  logic       bus_shared_in,
   output logic       cpu_ack,
   output logic       we,
   output line_st_e   wst,
   output logic       bus_req_valid,
   output bus_op_e    bus_req_op
);

   ctl_st_e  st_q, st_d;
   logic     line_ok;
   line_st_e fill_st;

   assign line_ok = cpu_hit && (cur != LS_I);
   assign fill_st = cpu_wr ? LS_M : (bus_shared_in ? LS_S : LS_E);

   always_comb begin
      st_d          = st_q;
      cpu_ack       = 1'b0;
      we            = 1'b0;
      wst           = cur;
      bus_req_valid = 1'b0;
      bus_req_op    = BOP_RD;
      unique case (st_q)
         CS_IDLE: begin
            if (cpu_req && !conflict) begin
               if (line_ok && !cpu_wr) begin
                  cpu_ack = 1'b1;
               end else if (line_ok && cur != LS_S) begin
                  cpu_ack = 1'b1;
                  we      = 1'b1;
                  wst     = LS_M;
               end else if (line_ok) begin
                  st_d = CS_UPG;
               end else if (!cpu_hit && cur == LS_M) begin
                  st_d = CS_WB;
               end else begin
                  st_d = CS_FILL;
               end
            end
         end
         CS_WB: begin
            if (conflict) begin
               st_d = CS_IDLE;
            end else begin
               bus_req_valid = 1'b1;
               bus_req_op    = BOP_WB;
               if (bus_gnt) begin
                  we   = 1'b1;
                  wst  = LS_I;
                  st_d = CS_FILL;
               end
            end
         end
         CS_UPG: begin
            if (conflict) begin
               st_d = CS_IDLE;
            end else begin
               bus_req_valid = 1'b1;
               bus_req_op    = BOP_INV;
               if (bus_gnt) begin
                  we      = 1'b1;
                  wst     = LS_M;
                  cpu_ack = 1'b1;
                  st_d    = CS_IDLE;
               end
            end
         end
         CS_FILL: begin
            if (conflict) begin
               st_d = CS_IDLE;
            end else begin
               bus_req_valid = 1'b1;
               bus_req_op    = cpu_wr ? BOP_RDX : BOP_RD;
               if (bus_gnt) begin
                  we      = 1'b1;
                  wst     = fill_st;
                  cpu_ack = 1'b1;
                  st_d    = CS_IDLE;
               end
            end
         end
         default: st_d = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= CS_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_lc_pkg::*;
#(
   parameter int LINES = 16,
   localparam int IW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_wr,
   input  logic [IW-1:0] cpu_idx,
   input  logic          cpu_hit,
   output logic          cpu_ack,
   output logic [1:0]    cpu_line_state,
   input  logic          snp_valid,
   input  logic [1:0]    snp_op,
   input  logic [IW-1:0] snp_idx,
   input  logic          snp_hit,
   output logic          snp_shared_out,
   output logic          snp_flush,
   output logic          bus_req_valid,
   output logic [1:0]    bus_req_op,
   input  logic          bus_gnt,
   input  logic          bus_shared_in
);

   line_st_e  cpu_cur, snp_cur, cpu_wst;
   snp_resp_t sresp;
   logic      cpu_we, conflict;
   bus_op_e   req_op;

   assign conflict = snp_valid && (snp_idx == cpu_idx);

   mesi_lc_state_array #(.LINES(LINES)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (cpu_idx),
      .ra_st  (cpu_cur),
      .rb_idx (snp_idx),
      .rb_st  (snp_cur),
      .wa_en  (sresp.upd),
      .wa_idx (snp_idx),
      .wa_st  (sresp.nxt),
      .wb_en  (cpu_we),
      .wb_idx (cpu_idx),
      .wb_st  (cpu_wst)
   );

   mesi_lc_snoop u_snoop (
      .snp_valid (snp_valid),
      .snp_op    (snp_op),
      .snp_hit   (snp_hit),
      .cur       (snp_cur),
      .resp      (sresp)
   );

   mesi_lc_cpu_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_wr        (cpu_wr),
      .cpu_hit       (cpu_hit),
      .cur           (cpu_cur),
      .conflict      (conflict),
      .bus_gnt       (bus_gnt),
      .bus_shared_in (bus_shared_in),
      .cpu_ack       (cpu_ack),
      .we            (cpu_we),
      .wst           (cpu_wst),
      .bus_req_valid (bus_req_valid),
      .bus_req_op    (req_op)
   );

   assign bus_req_op     = req_op;
   assign cpu_line_state = cpu_cur;
   assign snp_shared_out = sresp.shared;
   assign snp_flush      = sresp.flush;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
   parameter int LINES = 16,
   localparam int IW = $clog2(LINES)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_wr,
   input logic [IW-1:0] cpu_idx,
   input logic          cpu_hit,
   input logic          cpu_ack,
   input logic [1:0]    cpu_line_state,
   input logic          snp_valid,
   input logic [1:0]    snp_op,
   input logic [IW-1:0] snp_idx,
   input logic          snp_hit,
   input logic          snp_shared_out,
   input logic          snp_flush,
   input logic          bus_req_valid,
   input logic [1:0]    bus_req_op,
   input logic          bus_gnt,
   input logic          bus_shared_in
);

   assert_read_ack_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_wr && cpu_ack) |=>
         (cpu_idx != $past(cpu_idx)) || (cpu_line_state != 2'd0));

   assert_write_ack_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_wr && cpu_ack) |=>
         (cpu_idx != $past(cpu_idx)) || (cpu_line_state == 2'd3));

   assert_inv_from_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == 2'd2) |-> (cpu_line_state == 2'd1));

   assert_shared_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared_out |-> (snp_valid && snp_hit && snp_op == 2'd0));

   assert_flush_on_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_valid && snp_hit && snp_op != 2'd3));

   assert_wb_of_dirty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_op == 2'd3) |-> (cpu_line_state == 2'd3 && !cpu_hit));

   assert_snoop_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_idx == cpu_idx) |-> (!bus_req_valid && !cpu_ack));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LINES = 8;
   localparam int IW = $clog2(LINES);

   logic clk = 1'b0;
   logic rst_n;
   logic cpu_req, cpu_wr, cpu_hit, cpu_ack;
   logic [IW-1:0] cpu_idx, snp_idx;
   logic [1:0] cpu_line_state, snp_op, bus_req_op;
   logic snp_valid, snp_hit, snp_shared_out, snp_flush;
   logic bus_req_valid, bus_gnt, bus_shared_in;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic [1:0] model [LINES];

   always #(CLK_PERIOD/2) clk = ~clk;

   mesi_line_ctrl #(.LINES(LINES)) dut (.*);

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic get_state(input int idx, output logic [1:0] st);
      @(negedge clk);
      cpu_idx = IW'(idx);
      #1;
      st = cpu_line_state;
   endtask

   task automatic cpu_op(input bit wr, input int idx, input bit hit, input bit shr, input int dly,
                         output int nops, output logic [1:0] o0, output logic [1:0] o1, output int cyc);
      int waitc = 0;
      nops = 0; o0 = 2'd0; o1 = 2'd0; cyc = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_idx = IW'(idx); cpu_hit = hit; bus_gnt = 1'b0;
      forever begin
         #1;
         if (bus_req_valid) begin
            if (waitc >= dly) begin
               bus_gnt = 1'b1; bus_shared_in = shr;
               if (nops == 0) o0 = bus_req_op; else o1 = bus_req_op;
               nops++;
               #1;
            end else begin
               waitc++;
            end
         end
         if (cpu_ack) break;
         if (cyc > 60) begin
            chk(1'b0, "timeout", "cpu request cycles", cyc, 60);
            break;
         end
         @(negedge clk);
         bus_gnt = 1'b0;
         cyc++;
      end
      @(negedge clk);
      cpu_req = 1'b0; bus_gnt = 1'b0;
   endtask

   task automatic snoop(input logic [1:0] op, input int idx, input bit hit, output bit sh, output bit fl);
      @(negedge clk);
      snp_valid = 1'b1; snp_op = op; snp_idx = IW'(idx); snp_hit = hit;
      #1;
      sh = snp_shared_out; fl = snp_flush;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   function automatic void exp_cpu(input logic [1:0] s, input bit wr, input bit hit, input bit shr,
                                   output int nops, output logic [1:0] o0, output logic [1:0] o1,
                                   output logic [1:0] ns);
      bit ok = hit && (s != 2'd0);
      logic [1:0] fop = wr ? 2'd1 : 2'd0;
      o0 = 2'd0; o1 = 2'd0;
      if (ok && !wr) begin nops = 0; ns = s; end
      else if (ok && s != 2'd1) begin nops = 0; ns = 2'd3; end
      else if (ok) begin nops = 1; o0 = 2'd2; ns = 2'd3; end
      else begin
         if (!hit && s == 2'd3) begin nops = 2; o0 = 2'd3; o1 = fop; end
         else begin nops = 1; o0 = fop; end
         ns = wr ? 2'd3 : (shr ? 2'd1 : 2'd2);
      end
   endfunction

   function automatic void exp_snp(input logic [1:0] s, input logic [1:0] op, input bit hit,
                                   output bit sh, output bit fl, output logic [1:0] ns);
      sh = 0; fl = 0; ns = s;
      if (hit && s != 2'd0) begin
         if (op == 2'd0) begin sh = 1; fl = (s == 2'd3); ns = 2'd1; end
         else if (op != 2'd3) begin fl = (s == 2'd3); ns = 2'd0; end
      end
   endfunction

   task automatic do_cpu(input string req, input bit wr, input int idx, input bit hit, input bit shr, input int dly);
      int n, en, cyc;
      logic [1:0] a0, a1, e0, e1, ens, st;
      exp_cpu(model[idx], wr, hit, shr, en, e0, e1, ens);
      cpu_op(wr, idx, hit, shr, dly, n, a0, a1, cyc);
      chk(n == en, req, "bus op count", n, en);
      if (n == en && en >= 1) chk(a0 == e0, req, "first bus op", a0, e0);
      if (n == en && en == 2) chk(a1 == e1, req, "second bus op", a1, e1);
      if (en == 0) chk(cyc == 0, req, "ack latency", cyc, 0);
      get_state(idx, st);
      chk(st == ens, req, "line state", st, ens);
      model[idx] = ens;
   endtask

   task automatic do_snp(input string req, input logic [1:0] op, input int idx, input bit hit);
      bit sh, fl, esh, efl;
      logic [1:0] ens, st;
      exp_snp(model[idx], op, hit, esh, efl, ens);
      snoop(op, idx, hit, sh, fl);
      chk(sh == esh, req, "shared out", sh, esh);
      chk(fl == efl, req, "flush", fl, efl);
      get_state(idx, st);
      chk(st == ens, req, "line state", st, ens);
      model[idx] = ens;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [1:0] st;
      int seed;
      rst_n = 1'b0;
      cpu_req = 0; cpu_wr = 0; cpu_idx = '0; cpu_hit = 0;
      snp_valid = 0; snp_op = 0; snp_idx = '0; snp_hit = 0;
      bus_gnt = 0; bus_shared_in = 0;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < LINES; i++) begin
         get_state(i, st);
         chk(st == 2'd0, "R1", "reset state", st, 0);
         model[i] = 2'd0;
      end

      do_cpu("R3", 0, 1, 1, 0, 0);           // read miss, no sharer -> E
      do_cpu("R2", 0, 1, 1, 0, 0);           // read hit on E
      do_cpu("R5", 1, 1, 1, 0, 0);           // silent E -> M
      do_cpu("R2", 0, 1, 1, 0, 0);           // read hit on M
      do_cpu("R3", 0, 2, 1, 1, 1);           // read miss, sharer -> S
      do_cpu("R6", 1, 2, 1, 0, 2);           // upgrade through invalidate
      do_cpu("R4", 1, 3, 0, 0, 1);           // write miss -> M
      do_snp("R8", 2'd0, 3, 1);              // snoop read on M
      do_cpu("R3", 0, 4, 1, 0, 0);
      do_snp("R7", 2'd0, 4, 1);              // snoop read on E
      do_snp("R9", 2'd1, 2, 1);              // snoop readx on M
      do_snp("R10", 2'd2, 4, 1);             // snoop invalidate on S
      do_snp("R10", 2'd1, 3, 0);             // tag miss: no effect
      do_snp("R10", 2'd3, 3, 1);             // no-op code: no effect
      do_cpu("R11", 0, 1, 0, 0, 1);          // dirty victim then fill

      // R12: snoop hits a line whose upgrade is pending
      do_cpu("R12", 0, 5, 1, 1, 0);          // line 5 -> S
      begin
         int n, cyc;
         logic [1:0] a0, a1;
         bit sh, fl;
         fork
            cpu_op(1, 5, 1, 0, 3, n, a0, a1, cyc);
            begin
               @(negedge clk);
               snoop(2'd1, 5, 1, sh, fl);
            end
         join
         chk(n == 1, "R12", "bus op count", n, 1);
         chk(a0 == 2'd1, "R12", "retried op", a0, 1);
         chk(sh == 0 && fl == 0, "R12", "snoop response", {sh, fl}, 0);
         get_state(5, st);
         chk(st == 2'd3, "R12", "line state", st, 3);
         model[5] = 2'd3;
      end

      for (int k = 0; k < 300; k++) begin
         int idx = int'($urandom % LINES);
         if ($urandom % 2 == 0)
            do_cpu("random cpu", bit'($urandom % 2), idx, ($urandom % 4) != 0,
                   bit'($urandom % 2), int'($urandom % 3));
         else
            do_snp("random snoop", 2'($urandom % 4), idx, ($urandom % 4) != 0);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule